// File: doc/BRIEF.md
# Interrupt-capable 32-pin GPIO port

This block is a general-purpose I/O port of 32 pins, controlled through a plain 32-bit register bus with a single-cycle select/write strobe and combinational read data. Software sets, for every pin, whether the pin drives or listens. It sets the value driven, and it can read the level actually present on each pad. The pad driver is modelled as two vectors, an output value and an output enable, so the surrounding pad ring builds the tri-state cell.

Each pin can also raise an interrupt. A 2-bit trigger code per pin picks one of four conditions: low level, high level, rising edge or falling edge. A separate per-pin bit selects triggering on any transition and overrides the code. A detected condition sets a sticky status bit whether or not the pin is masked. Software clears a status bit by writing a one to it. Two request outputs each summarise masked status for one half of the port. Pad levels are brought into the clock domain through two flops before any use.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every register reads zero, `padOe` is zero (all pins inputs), and both `irqLo` and `irqHi` are low.
- R2: `padOe[i]` follows bit i of the direction register (1 = output) and `padOut[i]` follows bit i of the data register. Reading the data register returns the stored drive value, not the pin level.
- R3: The pad-level register (offset 0x08) returns each pin's level after a two-flop synchronizer, for output pins as well, two clock edges after the pin changes. Writes to it change no state.
- R4: Trigger code 0 = level low, 1 = level high, 2 = rising edge, 3 = falling edge. Pin n < 16 takes its code from bits [2n+1:2n] of the word at 0x0C. Pin n ≥ 16 takes it from bits [2(n-16)+1:2(n-16)] of the word at 0x10.
- R5: An edge is detected by comparing the synchronized level with its value one cycle earlier. A pad change becomes visible in the status register three clock edges later.
- R6: When a pin's bit in the any-edge register (0x1C) is 1, both rising and falling transitions set its status bit, and its trigger code has no effect.
- R7: With a level trigger, the status bit is set again on every cycle the level holds. If a hardware set and a software clear hit the same bit in the same cycle, the bit stays set.
- R8: The status register (0x18) is sticky. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R9: Status bits are set regardless of the mask (0x14). `irqLo` is high when any of pins 0–15 has both status and mask set. `irqHi` is the same for pins 16–31.
- R10: Word offsets are 0x00 data, 0x04 direction, 0x08 pad level, 0x0C/0x10 trigger codes, 0x14 mask, 0x18 status, 0x1C any-edge. Address bits [1:0] are ignored. Offsets of 0x20 and above read as zero, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| busSel | input | 1 | Bus access strobe |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the cycle of the read |
| padIn | input | 32 | Pin levels from the pads |
| padOut | output | 32 | Value to drive on each pin |
| padOe | output | 32 | Output enable per pin |
| irqLo | output | 1 | Request for pins 0–15 |
| irqHi | output | 1 | Request for pins 16–31 |

## Verification
A hardware status set and a software write-one clear can land on the same status bit in the same cycle. The bench provokes this by holding a pin in its active level under a level-high trigger and then writing a clear of all ones. The status read that follows must still show that pin's bit, while a clear issued after the level has been removed must leave the bit at zero. An assertion in the datapath checks on every cycle that a bit whose trigger fired reads as set afterwards, whatever the clear did.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // word index decoded from address bits [4:2]
  localparam logic [2:0] IDX_DATA   = 3'd0;
  localparam logic [2:0] IDX_DIR    = 3'd1;
  localparam logic [2:0] IDX_PAD    = 3'd2;
  localparam logic [2:0] IDX_CFGLO  = 3'd3;
  localparam logic [2:0] IDX_CFGHI  = 3'd4;
  localparam logic [2:0] IDX_MASK   = 3'd5;
  localparam logic [2:0] IDX_STATUS = 3'd6;
  localparam logic [2:0] IDX_ANYEDGE = 3'd7;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'd0,
    TRIG_HIGH = 2'd1,
    TRIG_RISE = 2'd2,
    TRIG_FALL = 2'd3
  } trig_e;

  typedef struct packed {
    logic       wrData;
    logic       wrDir;
    logic       wrCfgLo;
    logic       wrCfgHi;
    logic       wrMask;
    logic       wrClr;
    logic       wrAnyEdge;
    logic       rdHit;
    logic [2:0] rdIdx;
  } strobes_t;

endpackage

// File: rtl/gpio_bus_decode.sv
module gpio_bus_decode
  import gpio_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  output strobes_t          strb
);
  localparam int MAP_BITS = 5;

  logic       mapped;
  logic [2:0] idx;
  logic       unusedAddrBits;

  assign unusedAddrBits = ^busAddr[1:0];
  assign mapped = (busAddr[ADDR_W-1:MAP_BITS] == '0);
  assign idx    = busAddr[MAP_BITS-1:2];

  always_comb begin
    strb       = '0;
    strb.rdIdx = idx;
    strb.rdHit = busSel && !busWe && mapped;
    if (busSel && busWe && mapped) begin
      case (idx)
        IDX_DATA:    strb.wrData    = 1'b1;
        IDX_DIR:     strb.wrDir     = 1'b1;
        IDX_CFGLO:   strb.wrCfgLo   = 1'b1;
        IDX_CFGHI:   strb.wrCfgHi   = 1'b1;
        IDX_MASK:    strb.wrMask    = 1'b1;
        IDX_STATUS:  strb.wrClr     = 1'b1;
        IDX_ANYEDGE: strb.wrAnyEdge = 1'b1;
        default:     ;
      endcase
    end
  end

  // R10: at most one register is written per access
  assert_single_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrData, strb.wrDir, strb.wrCfgLo, strb.wrCfgHi,
              strb.wrMask, strb.wrClr, strb.wrAnyEdge}));

  // R3: a write to the pad-level word raises no strobe
  assert_pad_readonly_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWe && busAddr == ADDR_W'(8)) |->
      !(strb.wrData || strb.wrDir || strb.wrCfgLo || strb.wrCfgHi ||
        strb.wrMask || strb.wrClr || strb.wrAnyEdge));

endmodule

// File: rtl/gpio_port_core.sv
module gpio_port_core
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         strb,
  input  logic [NPINS-1:0] busWdata,
  output logic [NPINS-1:0] busRdata,
  input  logic [NPINS-1:0] padIn,
  output logic [NPINS-1:0] padOut,
  output logic [NPINS-1:0] padOe,
  output logic             irqLo,
  output logic             irqHi
);
  localparam int HALF = NPINS / 2;

  logic [NPINS-1:0] dataQ, dirQ, cfgLoQ, cfgHiQ, maskQ, statusQ, anyEdgeQ;
  logic [NPINS-1:0] sync1Q, sync2Q, prevQ;
  logic [NPINS-1:0] hitVec;
  logic [NPINS-1:0] clrVec;
  logic             armedQ;

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataQ    <= '0;
      dirQ     <= '0;
      cfgLoQ   <= '0;
      cfgHiQ   <= '0;
      maskQ    <= '0;
      anyEdgeQ <= '0;
    end else begin
      if (strb.wrData)    dataQ    <= busWdata;
      if (strb.wrDir)     dirQ     <= busWdata;
      if (strb.wrCfgLo)   cfgLoQ   <= busWdata;
      if (strb.wrCfgHi)   cfgHiQ   <= busWdata;
      if (strb.wrMask)    maskQ    <= busWdata;
      if (strb.wrAnyEdge) anyEdgeQ <= busWdata;
    end
  end

  // pad synchronizer plus one-cycle history for edge compare
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sync1Q <= '0;
      sync2Q <= '0;
      prevQ  <= '0;
    end else begin
      sync1Q <= padIn;
      sync2Q <= sync1Q;
      prevQ  <= sync2Q;
    end
  end

  // per-pin trigger evaluation
  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    trig_e code;
    if (i < HALF) begin : g_lo
      assign code = trig_e'(cfgLoQ[2*i +: 2]);
    end else begin : g_hi
      assign code = trig_e'(cfgHiQ[2*(i-HALF) +: 2]);
    end
    always_comb begin
      if (anyEdgeQ[i]) begin
        hitVec[i] = sync2Q[i] ^ prevQ[i];
      end else begin
        case (code)
          TRIG_LOW:  hitVec[i] = !sync2Q[i];
          TRIG_HIGH: hitVec[i] = sync2Q[i];
          TRIG_RISE: hitVec[i] = sync2Q[i] && !prevQ[i];
          default:   hitVec[i] = !sync2Q[i] && prevQ[i];
        endcase
      end
    end
  end

  assign clrVec = strb.wrClr ? busWdata : '0;

  // sticky status, hardware set has priority over clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
      armedQ  <= 1'b0;
    end else begin
      statusQ <= (statusQ & ~clrVec) | hitVec;
      armedQ  <= 1'b1;
    end
  end

  assign padOut = dataQ;
  assign padOe  = dirQ;
  assign irqLo  = |(statusQ[HALF-1:0] & maskQ[HALF-1:0]);
  assign irqHi  = |(statusQ[NPINS-1:HALF] & maskQ[NPINS-1:HALF]);

  always_comb begin
    busRdata = '0;
    if (strb.rdHit) begin
      case (strb.rdIdx)
        IDX_DATA:    busRdata = dataQ;
        IDX_DIR:     busRdata = dirQ;
        IDX_PAD:     busRdata = sync2Q;
        IDX_CFGLO:   busRdata = cfgLoQ;
        IDX_CFGHI:   busRdata = cfgHiQ;
        IDX_MASK:    busRdata = maskQ;
        IDX_STATUS:  busRdata = statusQ;
        default:     busRdata = anyEdgeQ;
      endcase
    end
  end

  // R8: cleared bits with no coincident hit read zero next cycle
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrClr |=> ((statusQ & $past(busWdata & ~hitVec)) == '0));

  // R8: without a clear write, no status bit ever falls
  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrClr |=> (($past(statusQ) & ~statusQ) == '0));

  // R7: a fired trigger always shows in status, even under a clear
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rstN)
    armedQ |-> (($past(hitVec) & ~statusQ) == '0));

  // R9: with all pins masked both requests stay low
  assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ == '0) |-> (!irqLo && !irqHi));

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [NPINS-1:0]  busWdata,
  output logic [NPINS-1:0]  busRdata,
  input  logic [NPINS-1:0]  padIn,
  output logic [NPINS-1:0]  padOut,
  output logic [NPINS-1:0]  padOe,
  output logic              irqLo,
  output logic              irqHi
);
  strobes_t strb;

  gpio_bus_decode #(.ADDR_W(ADDR_W)) u_decode (
    .clk     (clk),
    .rstN    (rstN),
    .busSel  (busSel),
    .busWe   (busWe),
    .busAddr (busAddr),
    .strb    (strb)
  );

  gpio_port_core #(.NPINS(NPINS)) u_core (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .padIn    (padIn),
    .padOut   (padOut),
    .padOe    (padOe),
    .irqLo    (irqLo),
    .irqHi    (irqHi)
  );

endmodule

// File: tb/gpio_irq_port_bench.sv
module gpio_irq_port_bench;
  localparam logic [7:0] A_DATA = 8'h00, A_DIR = 8'h04, A_PAD = 8'h08,
                         A_CFGLO = 8'h0C, A_CFGHI = 8'h10, A_MASK = 8'h14,
                         A_STAT = 8'h18, A_ANY = 8'h1C;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sel = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata, padIn, padOut, padOe, extIn = '0;
  logic        irqLo, irqHi;
  int          total = 0, bad = 0;
  logic        done = 1'b0;

  always #5 clk = ~clk;

  // pad ring model: driven pins show the driven value
  assign padIn = (padOe & padOut) | (~padOe & extIn);

  gpio_irq_port u_gpio_irq_port (
    .clk(clk), .rstN(rstN), .busSel(sel), .busWe(we), .busAddr(addr),
    .busWdata(wdata), .busRdata(rdata), .padIn(padIn), .padOut(padOut),
    .padOe(padOe), .irqLo(irqLo), .irqHi(irqHi)
  );

  // {write, addr, data (write value or expected read), requirement}
  localparam int NVEC = 19;
  localparam logic [44:0] VEC [NVEC] = '{
    {1'b1, A_DATA,  32'h1234_5678, 4'd2},
    {1'b0, A_DATA,  32'h1234_5678, 4'd2},
    {1'b1, A_DIR,   32'h0000_FF00, 4'd2},
    {1'b0, A_DIR,   32'h0000_FF00, 4'd2},
    {1'b0, 8'h05,   32'h0000_FF00, 4'd10},
    {1'b1, A_CFGLO, 32'hDEAD_BEEF, 4'd10},
    {1'b0, A_CFGLO, 32'hDEAD_BEEF, 4'd10},
    {1'b1, A_CFGHI, 32'h0F0F_0F0F, 4'd10},
    {1'b0, A_CFGHI, 32'h0F0F_0F0F, 4'd10},
    {1'b1, A_MASK,  32'h8000_0001, 4'd10},
    {1'b0, A_MASK,  32'h8000_0001, 4'd10},
    {1'b1, A_MASK,  32'h0000_0000, 4'd10},
    {1'b1, A_ANY,   32'h00F0_00F0, 4'd10},
    {1'b0, A_ANY,   32'h00F0_00F0, 4'd10},
    {1'b1, 8'h20,   32'hFFFF_FFFF, 4'd10},
    {1'b0, 8'h20,   32'h0000_0000, 4'd10},
    {1'b0, 8'h3C,   32'h0000_0000, 4'd10},
    {1'b1, A_DIR,   32'h0000_0000, 4'd2},
    {1'b0, A_DATA,  32'h1234_5678, 4'd10}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    sel = 1'b0;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic settle();
    waitCyc(5);
    busWrite(A_STAT, 32'hFFFF_FFFF);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] r;
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(3);

    // reset state, R1
    busRead(A_DATA, r);  chk("R1 data", r, 32'h0);
    busRead(A_DIR, r);   chk("R1 dir", r, 32'h0);
    busRead(A_MASK, r);  chk("R1 mask", r, 32'h0);
    busRead(A_ANY, r);   chk("R1 anyedge", r, 32'h0);
    chk("R1 padOe", padOe, 32'h0);
    chk("R1 irq", {30'h0, irqHi, irqLo}, 32'h0);
    // all pins low with reset code 0 (level low): every status bit set, R7
    busRead(A_STAT, r);  chk("R7 level-low after reset", r, 32'hFFFF_FFFF);

    extIn = 32'hFFFF_FFFF;
    waitCyc(4);

    // register table walk
    for (int k = 0; k < NVEC; k++) begin
      if (VEC[k][44]) begin
        busWrite(VEC[k][43:36], VEC[k][35:4]);
      end else begin
        busRead(VEC[k][43:36], r);
        chk($sformatf("R%0d table %0d", VEC[k][3:0], k), r, VEC[k][35:4]);
      end
    end

    // all pins rising, pin 17 falling (second word bits [3:2] = 3)
    busWrite(A_CFGLO, 32'hAAAA_AAAA);
    busWrite(A_CFGHI, 32'hAAAA_AAAE);
    busWrite(A_ANY, 32'h0);
    busWrite(A_DATA, 32'h0);
    settle();
    busRead(A_STAT, r);  chk("R8 cleared all", r, 32'h0);

    // R4 / R5: pin 0 rising only
    extIn[0] = 1'b0;  waitCyc(4);
    busRead(A_STAT, r);  chk("R4 rising code ignores fall", r, 32'h0);
    extIn[0] = 1'b1;  waitCyc(4);
    busRead(A_STAT, r);  chk("R5 rising edge sets", r, 32'h1);
    chk("R9 unmasked status no irq", {31'h0, irqLo}, 32'h0);
    busWrite(A_MASK, 32'h1);
    chk("R9 irqLo on", {30'h0, irqHi, irqLo}, 32'h1);
    busWrite(A_STAT, 32'h0);
    busRead(A_STAT, r);  chk("R8 write zero keeps", r, 32'h1);
    busWrite(A_STAT, 32'h1);
    busRead(A_STAT, r);  chk("R8 write one clears", r, 32'h0);
    chk("R9 irqLo off", {31'h0, irqLo}, 32'h0);
    busWrite(A_MASK, 32'h0);

    // R4: pin 17 falling from the second word
    extIn[17] = 1'b0;  waitCyc(4);
    busRead(A_STAT, r);  chk("R4 pin17 falling", r, 32'h0002_0000);
    busWrite(A_MASK, 32'h0002_0000);
    chk("R9 irqHi only", {30'h0, irqHi, irqLo}, 32'h2);
    busWrite(A_MASK, 32'h0);
    extIn[17] = 1'b1;
    settle();

    // R6: any-edge on pin 5 overrides rising code
    busWrite(A_ANY, 32'h20);
    extIn[5] = 1'b0;  waitCyc(4);
    busRead(A_STAT, r);  chk("R6 falling with any-edge", r, 32'h20);
    busWrite(A_STAT, 32'hFFFF_FFFF);
    extIn[5] = 1'b1;  waitCyc(4);
    busRead(A_STAT, r);  chk("R6 rising with any-edge", r, 32'h20);
    busWrite(A_ANY, 32'h0);
    busWrite(A_STAT, 32'hFFFF_FFFF);

    // R2 / R3: pin 8 driven low while the outside pulls it high
    busWrite(A_DIR, 32'h100);
    waitCyc(4);
    busRead(A_PAD, r);   chk("R3 pad shows driven level", r, 32'hFFFF_FEFF);
    chk("R2 padOe", padOe, 32'h100);
    chk("R2 padOut", padOut, 32'h0);
    busWrite(A_PAD, 32'h0);
    busRead(A_DIR, r);   chk("R3 pad write leaves dir", r, 32'h100);
    busRead(A_PAD, r);   chk("R3 pad write ignored", r, 32'hFFFF_FEFF);
    busWrite(A_DIR, 32'h0);
    chk("R2 back to input", padOe, 32'h0);
    settle();

    // R7: level high on pin 2, clear collides with re-set
    busWrite(A_CFGLO, 32'hAAAA_AA9A);
    waitCyc(4);
    busRead(A_STAT, r);  chk("R7 level high sets", r, 32'h4);
    busWrite(A_STAT, 32'hFFFF_FFFF);
    busRead(A_STAT, r);  chk("R7 set wins over clear", r, 32'h4);
    extIn[2] = 1'b0;  waitCyc(4);
    busWrite(A_STAT, 32'hFFFF_FFFF);
    busRead(A_STAT, r);  chk("R7 clears once level gone", r, 32'h0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule